// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Control/Status Register

This block turns an asynchronous serial input into parallel bytes for a host. A free-running 16x oversampling tick paces it. The block finds each start bit and samples every following bit at its centre. It loads the received word into a receive data register and raises a receive interrupt. Frame shape comes from shared configuration inputs: the word is 7 or 8 data bits, parity is optional, and parity is odd or even. There is always one stop bit.

A host sees two registers through a simple read/write port: the data register and a control/status register. The control/status register holds three things. A receiver-enable bit gates all receive activity. A semaphore bit is free for software use. A sticky error flag collects parity, framing and overrun errors. Turning the receiver off resets the deserializer and cancels a pending interrupt. It keeps the low seven bits of the data register and forces the top bit to 0.

Top module: `uart_rx_status`

## Requirements
- R1: After reset, the status register reads 0x00, the data register reads 0x00 and rx_irq is 0.
- R2: With the receiver enabled (status bit 0 = 1) and 8-bit mode (cfg_eight = 1), a frame is received and loaded into the data register. The frame is a 0 start bit, 8 data bits least significant first, an optional parity bit and a 1 stop bit. rx_irq rises when the word is loaded.
- R3: In 7-bit mode (cfg_eight = 0) the frame carries 7 data bits. Bit 7 of the data register read value is always 0.
- R4: When cfg_par_en = 1, one parity bit follows the data. cfg_par_even = 1 expects an even count of ones over data plus parity, and 0 expects an odd count. A mismatch sets the error flag (status bit 7).
- R5: A 0 sampled at the stop bit centre sets the error flag. The word is still loaded.
- R6: If a new word is loaded while rx_irq is still set, the error flag is set (overrun) and the new word replaces the old one.
- R7: Reading the data register (host_sel = 0) clears rx_irq.
- R8: The error flag is cleared only by reset or by writing a 1 to status bit 7. Writing 0 there leaves it unchanged.
- R9: Status bit 1 is a semaphore that software reads and writes. It has no effect on reception.
- R10: Writing status bit 0 = 0 stops reception, resets the deserializer and clears rx_irq. It forces data register bit 7 to 0 and keeps bits 6:0. Frames sent while the receiver is off are not received.
- R11: A falling edge whose line is back at 1 by the centre of the start bit is a false start. It loads no word and the receiver returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Asynchronous serial input, idle high |
| tick16 | input | 1 | One-cycle pulse at 16x the bit rate |
| cfg_eight | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_par_en | input | 1 | 1: a parity bit follows the data |
| cfg_par_even | input | 1 | 1: even parity, 0: odd parity |
| host_sel | input | 1 | 0: data register, 1: control/status register |
| host_rd | input | 1 | Read strobe; a data register read clears rx_irq |
| host_wr | input | 1 | Write strobe (the data register ignores writes) |
| host_wdata | input | 8 | Write data; status bits 0 enable, 1 semaphore, 7 write-1-to-clear error |
| host_rdata | output | 8 | Read data of the selected register |
| rx_irq | output | 1 | Receive interrupt, set on each word load |

## Verification
Random bytes are sent under every mix of word length, parity enable and parity sense. This separates a wrong bit order or a wrong data-bit count from a wrong parity polarity. Some frames carry a flipped parity bit or a low stop bit, so each error source is seen to set the flag alone. Directed sequences cover the remaining cases: two frames without a read in between (overrun), a short low glitch (false start), and disabling with a word pending that has bit 7 set. These show that the data register keeps its low bits and that the disabled receiver ignores traffic.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
    localparam int WORD_W  = 8;
    localparam int IDX_W   = $clog2(WORD_W);

    // host register select
    localparam logic SEL_DATA = 1'b0;
    localparam logic SEL_CTRL = 1'b1;

    // control/status bit positions
    localparam int EN_POS  = 0;
    localparam int SEM_POS = 1;
    localparam int ERR_POS = 7;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              par_err;
        logic              frm_err;
    } rx_word_t;

    // 1 when the received parity bit disagrees with the selected sense
    function automatic logic parity_bad(input logic [WORD_W-1:0] d,
                                        input logic pbit,
                                        input logic even);
        return (^d ^ pbit) != !even;
    endfunction
endpackage

// File: rtl/rx_frame_sampler.sv
module rx_frame_sampler
    import uart_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  logic     tick,
    input  logic     rxd,
    input  logic     cfg_eight,
    input  logic     cfg_par_en,
    input  logic     cfg_par_even,
    output logic     done,
    output rx_word_t word
);
    localparam int CW   = $clog2(OVS);
    localparam int HALF = OVS / 2;

    logic [1:0]        sync_q;
    logic              line;
    rx_state_e         st;
    logic [CW-1:0]     cnt;
    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] sh;
    logic              prev;
    logic              pbit;
    logic              full_bit;
    logic [IDX_W-1:0]  last_idx;

    assign line     = sync_q[1];
    assign full_bit = (cnt == CW'(OVS - 1));
    assign last_idx = cfg_eight ? IDX_W'(WORD_W - 1) : IDX_W'(WORD_W - 2);

    always_ff @(posedge clk) begin
        if (rst) sync_q <= 2'b11;
        else     sync_q <= {sync_q[0], rxd};
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            st   <= RX_IDLE;
            cnt  <= '0;
            idx  <= '0;
            sh   <= '0;
            prev <= 1'b1;
            pbit <= 1'b0;
            done <= 1'b0;
            word <= '0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                unique case (st)
                    RX_IDLE: begin
                        prev <= line;
                        if (prev && !line) begin
                            st  <= RX_START;
                            cnt <= '0;
                        end
                    end
                    RX_START: begin
                        if (cnt == CW'(HALF - 1)) begin
                            cnt <= '0;
                            if (!line) begin
                                st  <= RX_DATA;
                                idx <= '0;
                                sh  <= '0;
                            end else begin
                                st   <= RX_IDLE;
                                prev <= line;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (full_bit) begin
                            cnt     <= '0;
                            sh[idx] <= line;
                            if (idx == last_idx) st <= cfg_par_en ? RX_PARITY : RX_STOP;
                            else                 idx <= idx + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_PARITY: begin
                        if (full_bit) begin
                            cnt  <= '0;
                            pbit <= line;
                            st   <= RX_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (full_bit) begin
                            cnt          <= '0;
                            done         <= 1'b1;
                            word.data    <= sh;
                            word.frm_err <= !line;
                            word.par_err <= cfg_par_en && parity_bad(sh, pbit, cfg_par_even);
                            st           <= RX_IDLE;
                            prev         <= line;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: st <= RX_IDLE;
                endcase
            end
        end
    end

    // R10
    idle_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (st == RX_IDLE && !done));

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R11
    start_needs_low_chk: assert property (@(posedge clk) disable iff (rst)
        (st == RX_IDLE && $past(st) == RX_START) |-> !done);
endmodule

// File: rtl/rx_host_regs.sv
module rx_host_regs
    import uart_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              done,
    input  rx_word_t          word,
    input  logic              cfg_eight,
    input  logic              host_sel,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata,
    output logic              en,
    output logic              irq
);
    logic [WORD_W-1:0] data_q;
    logic              sem_q;
    logic              err_q;
    logic              ctrl_wr;
    logic              data_rd;
    logic              new_err;

    assign ctrl_wr = host_wr && (host_sel == SEL_CTRL);
    assign data_rd = host_rd && (host_sel == SEL_DATA);
    assign new_err = done && (irq || word.par_err || word.frm_err);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            sem_q  <= 1'b0;
            err_q  <= 1'b0;
            en     <= 1'b0;
            irq    <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                en    <= host_wdata[EN_POS];
                sem_q <= host_wdata[SEM_POS];
            end

            if (new_err)                             err_q <= 1'b1;
            else if (ctrl_wr && host_wdata[ERR_POS]) err_q <= 1'b0;

            if (!en)          irq <= 1'b0;
            else if (done)    irq <= 1'b1;
            else if (data_rd) irq <= 1'b0;

            if (!en)       data_q[WORD_W-1] <= 1'b0;
            else if (done) data_q <= word.data;
        end
    end

    always_comb begin
        host_rdata = '0;
        if (host_sel == SEL_CTRL) begin
            host_rdata[EN_POS]  = en;
            host_rdata[SEM_POS] = sem_q;
            host_rdata[ERR_POS] = err_q;
        end else begin
            host_rdata = data_q;
            if (!cfg_eight) host_rdata[WORD_W-1] = 1'b0;
        end
    end

    // R7
    irq_read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (data_rd && !done && irq) |=> !irq);

    // R6
    overrun_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (done && irq) |=> err_q);

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (err_q && !(ctrl_wr && host_wdata[ERR_POS])) |=> err_q);

    // R10
    irq_off_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> !irq);
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
    import uart_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rxd,
    input  logic       tick16,
    input  logic       cfg_eight,
    input  logic       cfg_par_en,
    input  logic       cfg_par_even,
    input  logic       host_sel,
    input  logic       host_rd,
    input  logic       host_wr,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    output logic       rx_irq
);
    logic     rx_en;
    logic     rx_done;
    rx_word_t rx_word;

    rx_frame_sampler #(.OVS(OVS)) u_sampler (
        .clk          (clk),
        .rst          (rst),
        .en           (rx_en),
        .tick         (tick16),
        .rxd          (rxd),
        .cfg_eight    (cfg_eight),
        .cfg_par_en   (cfg_par_en),
        .cfg_par_even (cfg_par_even),
        .done         (rx_done),
        .word         (rx_word)
    );

    rx_host_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .done       (rx_done),
        .word       (rx_word),
        .cfg_eight  (cfg_eight),
        .host_sel   (host_sel),
        .host_rd    (host_rd),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .en         (rx_en),
        .irq        (rx_irq)
    );
endmodule

// File: tb/tb_uart_rx_status.sv
`timescale 1ns/1ps
module tb_uart_rx_status;
    localparam int TDIV    = 4;
    localparam int BIT_CYC = 16 * TDIV;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rxd = 1'b1;
    logic       tick16;
    logic       cfg_eight = 1'b1, cfg_par_en = 1'b0, cfg_par_even = 1'b0;
    logic       host_sel = 1'b0, host_rd = 1'b0, host_wr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       rx_irq;

    logic [1:0] tdiv = '0;
    int n_vec = 0, n_bad = 0;
    bit done_flag = 0;

    always #4 clk = ~clk;
    always @(posedge clk) tdiv <= tdiv + 1'b1;
    assign tick16 = (tdiv == 2'(TDIV - 1));

    uart_rx_status dut (.*);

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic host_read(input logic sel, output logic [7:0] v);
        @(negedge clk);
        host_sel = sel; host_rd = 1'b1;
        #1 v = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic host_write(input logic sel, input logic [7:0] v);
        @(negedge clk);
        host_sel = sel; host_wr = 1'b1; host_wdata = v;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic send_bit(input logic v);
        @(negedge clk);
        rxd = v;
        repeat (BIT_CYC - 1) @(negedge clk);
    endtask

    function automatic logic par_of(input logic [7:0] d, input bit eight, input bit even);
        logic ones = ^(eight ? d : (d & 8'h7F));
        return even ? ones : !ones;
    endfunction

    task automatic send_frame(input logic [7:0] d, input bit bad_par, input bit bad_stop);
        int nb = cfg_eight ? 8 : 7;
        send_bit(1'b0);
        for (int i = 0; i < nb; i++) send_bit(d[i]);
        if (cfg_par_en) send_bit(par_of(d, cfg_eight, cfg_par_even) ^ bad_par);
        send_bit(!bad_stop);
        if (bad_stop) send_bit(1'b1);
        repeat (8) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        logic [7:0] d;
        bit bp, bs;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 irq", {7'b0, rx_irq}, 8'h00);
        host_read(1'b1, v); check("R1 status", v, 8'h00);
        host_read(1'b0, v); check("R1 data", v, 8'h00);

        // R9 semaphore write/read, enable receiver
        host_write(1'b1, 8'h03);
        host_read(1'b1, v); check("R9 semaphore set", v, 8'h03);

        // R2 directed 8-bit frame
        send_frame(8'hA5, 0, 0);
        check("R2 irq raised", {7'b0, rx_irq}, 8'h01);
        host_read(1'b0, v); check("R2 data", v, 8'hA5);
        // R7 read clears irq
        check("R7 irq cleared", {7'b0, rx_irq}, 8'h00);
        host_read(1'b1, v); check("R9 no effect", v, 8'h03);

        // R3 seven-bit mode
        cfg_eight = 1'b0;
        send_frame(8'hFF, 0, 0);
        host_read(1'b0, v); check("R3 7-bit top bit zero", v, 8'h7F);
        cfg_eight = 1'b1;

        // R11 false start
        @(negedge clk); rxd = 1'b0;
        repeat (3 * TDIV) @(negedge clk);
        rxd = 1'b1;
        repeat (2 * BIT_CYC) @(negedge clk);
        check("R11 no word", {7'b0, rx_irq}, 8'h00);
        send_frame(8'h3C, 0, 0);
        host_read(1'b0, v); check("R11 next frame ok", v, 8'h3C);

        // R6 overrun
        send_frame(8'h11, 0, 0);
        send_frame(8'h22, 0, 0);
        host_read(1'b1, v); check("R6 overrun flag", v, 8'h83);
        host_read(1'b0, v); check("R6 new word kept", v, 8'h22);
        // R8 write 0 no effect, write 1 clears
        host_write(1'b1, 8'h03);
        host_read(1'b1, v); check("R8 write0 keeps", v, 8'h83);
        host_write(1'b1, 8'h83);
        host_read(1'b1, v); check("R8 write1 clears", v, 8'h03);

        // R5 framing error
        send_frame(8'h5A, 0, 1);
        host_read(1'b0, v); check("R5 word stored", v, 8'h5A);
        host_read(1'b1, v); check("R5 framing flag", v, 8'h83);
        host_write(1'b1, 8'h83);

        // R4 parity error, odd and even
        cfg_par_en = 1'b1; cfg_par_even = 1'b0;
        send_frame(8'h07, 1, 0);
        host_read(1'b0, v);
        host_read(1'b1, v); check("R4 odd parity error", v, 8'h83);
        host_write(1'b1, 8'h83);
        cfg_par_even = 1'b1;
        send_frame(8'h07, 0, 0);
        host_read(1'b0, v); check("R4 even parity data", v, 8'h07);
        host_read(1'b1, v); check("R4 even parity clean", v, 8'h03);
        cfg_par_en = 1'b0;

        // R10 disable with pending word
        send_frame(8'hC9, 0, 0);
        host_write(1'b1, 8'h02);
        @(negedge clk);
        check("R10 irq cleared", {7'b0, rx_irq}, 8'h00);
        host_read(1'b0, v); check("R10 bit7 cleared", v, 8'h49);
        send_frame(8'hFF, 0, 0);
        host_read(1'b0, v); check("R10 ignored while off", v, 8'h49);
        check("R10 no irq while off", {7'b0, rx_irq}, 8'h00);
        host_write(1'b1, 8'h01);

        // random frames: R2 R3 R4 R5
        for (int k = 0; k < 40; k++) begin
            d = 8'($urandom);
            @(negedge clk);
            cfg_eight    = 1'($urandom);
            cfg_par_en   = 1'($urandom);
            cfg_par_even = 1'($urandom);
            bp = cfg_par_en && ($urandom % 5 == 0);
            bs = ($urandom % 6 == 0);
            send_frame(d, bp, bs);
            check("R2 random irq", {7'b0, rx_irq}, 8'h01);
            host_read(1'b0, v);
            check("R2/R3 random data", v, cfg_eight ? d : (d & 8'h7F));
            host_read(1'b1, v);
            check("R4/R5 random status", v, {(bp | bs), 6'b0, 1'b1});
            host_write(1'b1, 8'h81);
        end

        finish_run();
    end
endmodule